// File: doc/BRIEF.md
# Clock Source Selector with Fractional Divider

The block picks one of ten clock sources and divides the chosen clock by a programmable ratio. Every source arrives as a one-cycle enable strobe in a single fast reference domain. The output is a one-cycle enable strobe for a downstream peripheral. The divide ratio has an integer part and a fractional part, and both widths are instance parameters. A fractional accumulator sometimes stretches an output period by one extra source pulse, so that over many periods the average ratio is integer plus fraction divided by 2^FRAC_W.

The source indices have fixed roles:
- Index 0 is ground.
- Index 1 is the main oscillator.
- Indices 2 and 3 are debug clocks that come back from other selectors.
- Indices 4 to 9 are fed by PLL channels, and an instance can mark any of them as unpopulated.

Software writes two words through a simple write port: a control word and a divisor word. A new source selection or a new divisor is held pending. It becomes active only at an output period boundary, so no partial period is ever emitted. The enable bit acts at once.

Top module: `clksel_fracdiv`

## Requirements
- R1: A write with `ctrl_we` high stores a control word. Bits [3:0] select the source index and bit 4 is the enable. A write with `div_we` high stores a divisor word. Bits [FRAC_W-1:0] are the fraction F and bits [FRAC_W+INT_W-1:FRAC_W] are the integer I. The output follows the strobes of the selected source only.
- R2: Index 0, and any index from 10 to 15, is ground: no output pulse is ever produced while it is selected.
- R3: A source index whose bit in the parameter SRC_PRESENT is 0 behaves as ground. By default index 9 is unpopulated.
- R4: With F = 0 and I >= 2, exactly one output pulse is produced for every I strobes of the selected source.
- R5: With a nonzero F, starting from a freshly enabled divider, 2^FRAC_W consecutive output periods consume exactly 2^FRAC_W*I + F source strobes. Each single period is I or I+1 strobes long.
- R6: With I equal to 0 or 1 and F = 0, every selected strobe yields an output pulse. The pulse is high in the cycle after the strobe and for that one cycle only.
- R7: While the enable is 0, the output stays low and the divider counters and accumulator are held at zero. After the enable is set again, the first period is a full I strobes long.
- R8: A new select or divisor written while the block is enabled takes effect only at the next output pulse. A period already in progress completes with the old setting. While the block is disabled, or while a grounded source is active, a write takes effect immediately.
- R9: An output pulse occurs only in the cycle after a strobe on the active source. Strobes on the other sources have no effect.
- R10: After reset the block is disabled and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| div_we | input | 1 | Write strobe for the divisor word |
| wr_data | input | WD | Write data (WD = max(INT_W+FRAC_W, 5)) |
| src_en | input | 10 | One enable strobe per source |
| clk_en_out | output | 1 | Divided output enable strobe |

## Verification
A write lands in the registers at the next clock edge. The output pulse is registered, so it is high in the cycle that follows the edge at which the completing source strobe was sampled. The bench drives inputs and samples the output on the falling edge. It checks the one-cycle pass-through latency at exactly the falling edge after that rising edge. For the divided cases it counts output pulses over a window of known strobe count, then idles a few cycles before it compares the count, so the last registered pulse has been seen. Boundary behaviour is checked by writing between strobes, while the source is quiet, and comparing the pulse count after a known number of further strobes.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int NSRC   = 10;
    localparam int SEL_W  = 4;
    localparam int EN_BIT = 4;
endpackage

// File: rtl/clksel_cfg.sv
module clksel_cfg #(
    parameter int INT_W = 8,
    parameter int FRAC_W = 4,
    parameter int WD = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ctrl_we,
    input  logic                           div_we,
    input  logic [WD-1:0]                  wr_data,
    input  logic                           apply,
    output logic                           en,
    output logic [clksel_pkg::SEL_W-1:0]   act_sel,
    output logic [INT_W-1:0]               act_int,
    output logic [FRAC_W-1:0]              act_frac
);
    import clksel_pkg::*;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  p_sel;
        logic [INT_W-1:0]  p_int;
        logic [FRAC_W-1:0] p_frac;
        logic [SEL_W-1:0]  a_sel;
        logic [INT_W-1:0]  a_int;
        logic [FRAC_W-1:0] a_frac;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.en    = wr_data[EN_BIT];
            st_d.p_sel = wr_data[SEL_W-1:0];
        end
        if (div_we) begin
            st_d.p_int  = wr_data[INT_W+FRAC_W-1:FRAC_W];
            st_d.p_frac = wr_data[FRAC_W-1:0];
        end
        if (apply) begin
            st_d.a_sel  = st_d.p_sel;
            st_d.a_int  = st_d.p_int;
            st_d.a_frac = st_d.p_frac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en       = st_q.en;
    assign act_sel  = st_q.a_sel;
    assign act_int  = st_q.a_int;
    assign act_frac = st_q.a_frac;
endmodule

// File: rtl/clksel_srcmux.sv
module clksel_srcmux #(
    parameter logic [clksel_pkg::NSRC-1:0] SRC_PRESENT = 10'b01_1111_1111
) (
    input  logic [clksel_pkg::NSRC-1:0]  src_en,
    input  logic [clksel_pkg::SEL_W-1:0] sel,
    output logic                         pulse,
    output logic                         grounded
);
    import clksel_pkg::*;

    logic [NSRC-1:0] usable;
    logic [NSRC-1:0] live;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == 0) begin : g_gnd
            assign usable[i] = 1'b0;
        end else begin : g_pop
            assign usable[i] = SRC_PRESENT[i];
        end
        assign live[i] = usable[i] & src_en[i];
    end

    always_comb begin
        pulse    = 1'b0;
        grounded = 1'b1;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) begin
                pulse    = live[i];
                grounded = ~usable[i];
            end
        end
    end
endmodule

// File: rtl/clksel_divcore.sv
module clksel_divcore #(
    parameter int INT_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pulse,
    input  logic [INT_W-1:0]  int_div,
    input  logic [FRAC_W-1:0] frac_div,
    output logic              fire,
    output logic              out
);
    typedef struct packed {
        logic [INT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
        logic              ext;
        logic              out;
    } div_t;

    div_t st_d, st_q;
    logic [INT_W-1:0]  ieff;
    logic [INT_W:0]    cnt_inc;
    logic [FRAC_W:0]   sum;

    always_comb begin
        st_d    = st_q;
        st_d.out = 1'b0;
        fire    = 1'b0;
        ieff    = (int_div == '0) ? INT_W'(1) : int_div;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        sum     = {1'b0, st_q.acc} + {1'b0, frac_div};
        if (!en) begin
            st_d = '0;
        end else if (pulse) begin
            if (cnt_inc >= {1'b0, ieff}) begin
                if (sum[FRAC_W] && !st_q.ext) begin
                    st_d.ext = 1'b1;
                end else begin
                    fire     = 1'b1;
                    st_d.cnt = '0;
                    st_d.acc = sum[FRAC_W-1:0];
                    st_d.ext = 1'b0;
                    st_d.out = 1'b1;
                end
            end else begin
                st_d.cnt = cnt_inc[INT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out = st_q.out;
endmodule

// File: rtl/clksel_fracdiv.sv
module clksel_fracdiv #(
    parameter int INT_W = 8,
    parameter int FRAC_W = 4,
    parameter logic [9:0] SRC_PRESENT = 10'b01_1111_1111,
    localparam int WD = (INT_W + FRAC_W > 5) ? INT_W + FRAC_W : 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          div_we,
    input  logic [WD-1:0] wr_data,
    input  logic [9:0]    src_en,
    output logic          clk_en_out
);
    import clksel_pkg::*;

    logic              cfg_en;
    logic [SEL_W-1:0]  act_sel;
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic              sel_pulse;
    logic              grounded;
    logic              fire;
    logic              apply;

    assign apply = ~cfg_en | fire | grounded;

    clksel_cfg #(.INT_W(INT_W), .FRAC_W(FRAC_W), .WD(WD)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .div_we(div_we),
        .wr_data(wr_data), .apply(apply), .en(cfg_en), .act_sel(act_sel),
        .act_int(act_int), .act_frac(act_frac)
    );

    clksel_srcmux #(.SRC_PRESENT(SRC_PRESENT)) u_mux (
        .src_en(src_en), .sel(act_sel), .pulse(sel_pulse), .grounded(grounded)
    );

    clksel_divcore #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .pulse(sel_pulse),
        .int_div(act_int), .frac_div(act_frac), .fire(fire), .out(clk_en_out)
    );
endmodule

// File: rtl/clksel_fracdiv_chk.sv
module clksel_fracdiv_chk #(
    parameter int INT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [9:0]       src_en,
    input logic             clk_en_out,
    input logic             en,
    input logic [3:0]       act_sel,
    input logic [INT_W-1:0] act_int,
    input logic             fire,
    input logic             grounded
);
    // R7: disabled divider emits nothing
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_en_out);

    // R2: ground source never produces a pulse
    a_r2_ground_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act_sel == 4'd0) |=> !clk_en_out);

    // R9: every output pulse follows some source strobe
    a_r9_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |-> $past(|src_en));

    // R8: active settings hold inside a running period
    a_r8_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fire && !grounded) |=> ($stable(act_int) && $stable(act_sel)));
endmodule

bind clksel_fracdiv clksel_fracdiv_chk #(.INT_W(INT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .clk_en_out(clk_en_out),
    .en(cfg_en), .act_sel(act_sel), .act_int(act_int), .fire(fire),
    .grounded(grounded)
);

// File: tb/clksel_fracdiv_test.sv
module clksel_fracdiv_test;
    localparam int INT_W = 8;
    localparam int FRAC_W = 4;
    localparam int WD = INT_W + FRAC_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_we = 1'b0;
    logic          div_we = 1'b0;
    logic [WD-1:0] wr_data = '0;
    logic [9:0]    src_en = '0;
    logic          clk_en_out;

    int applied = 0;
    int miscompares = 0;
    int seen = 0;
    int exp_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    clksel_fracdiv uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .div_we(div_we),
        .wr_data(wr_data), .src_en(src_en), .clk_en_out(clk_en_out)
    );

    // monitor: counts output pulses away from the rising edge
    always @(negedge clk) if (clk_en_out === 1'b1) seen = seen + 1;

    task automatic check(input string req, input int act, input int exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input bit en, input int sel);
        @(negedge clk);
        wr_data = '0;
        wr_data[4] = en;
        wr_data[3:0] = 4'(sel);
        ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_div(input int i, input int f);
        @(negedge clk);
        wr_data = {8'(i), 4'(f)};
        div_we = 1'b1;
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic strobe(input int idx, input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_en = 10'(1) << idx;
            @(negedge clk);
            src_en = '0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // driver: configure, push expected count, feed strobes; then compare
    task automatic run_case(input string req, input int sel, input int drive_idx,
                            input int i, input int f, input int n, input int gap,
                            input int expct);
        wr_ctrl(0, sel);
        wr_div(i, f);
        wr_ctrl(1, sel);
        idle(1);
        seen = 0;
        exp_q.push_back(expct);
        strobe(drive_idx, n, gap);
        idle(3);
        check(req, seen, exp_q.pop_front());
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R10 reset output low", int'(clk_en_out), 0);
        seen = 0;
        strobe(1, 5, 0);
        idle(2);
        check("R10 disabled after reset", seen, 0);

        run_case("R4 osc divide by 3", 1, 1, 3, 0, 48, 0, 16);
        run_case("R4 src4 divide by 5 gapped", 4, 4, 5, 0, 25, 2, 5);
        run_case("R5 frac 3+5/16", 1, 1, 3, 5, 53, 0, 16);
        run_case("R5 frac 1+15/16", 2, 2, 1, 15, 31, 1, 16);
        run_case("R5 frac 2+8/16 short window", 5, 5, 2, 8, 5, 0, 2);
        run_case("R6 divisor 0 passthrough", 3, 3, 0, 0, 20, 0, 20);
        run_case("R2 ground index 0", 0, 1, 1, 0, 10, 0, 0);
        run_case("R2 index 12 grounded", 12, 1, 1, 0, 10, 0, 0);
        run_case("R3 unpopulated index 9", 9, 9, 1, 0, 10, 0, 0);
        run_case("R9 other source ignored", 4, 6, 1, 0, 10, 0, 0);
        run_case("R1 select 7", 7, 7, 2, 0, 12, 0, 6);

        // R6 one-cycle latency and width
        wr_ctrl(0, 1); wr_div(1, 0); wr_ctrl(1, 1); idle(2);
        @(negedge clk); src_en = 10'b10;
        @(negedge clk); src_en = '0;
        check("R6 pulse one cycle after strobe", int'(clk_en_out), 1);
        @(negedge clk);
        check("R6 pulse one cycle wide", int'(clk_en_out), 0);

        // R7 disable mid-period resets counters
        wr_ctrl(0, 1); wr_div(3, 0); wr_ctrl(1, 1); idle(1);
        seen = 0;
        strobe(1, 2, 0);
        wr_ctrl(0, 1);
        strobe(1, 10, 0);
        idle(2);
        check("R7 no output while disabled", seen, 0);
        wr_ctrl(1, 1);
        strobe(1, 1, 0);
        idle(2);
        check("R7 fresh period after re-enable", seen, 0);
        strobe(1, 2, 0);
        idle(2);
        check("R7 full period completes", seen, 1);

        // R8 divisor change waits for boundary
        wr_ctrl(0, 1); wr_div(4, 0); wr_ctrl(1, 1); idle(1);
        seen = 0;
        strobe(1, 2, 0);
        wr_div(2, 0);
        strobe(1, 2, 0);
        idle(2);
        check("R8 old period finishes first", seen, 1);
        strobe(1, 2, 0);
        idle(2);
        check("R8 new divisor after boundary", seen, 2);

        // R8 select change waits for boundary
        wr_ctrl(0, 1); wr_div(3, 0); wr_ctrl(1, 1); idle(1);
        seen = 0;
        strobe(1, 1, 0);
        wr_ctrl(1, 4);
        strobe(4, 3, 0);
        idle(2);
        check("R8 select held until boundary", seen, 0);
        strobe(1, 2, 0);
        strobe(4, 3, 0);
        idle(2);
        check("R8 new select after boundary", seen, 2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            applied++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end
endmodule